// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Segment Decode

This block translates a 32-bit virtual address into a physical address for one access per cycle. The upper address bits select a segment. Two kernel windows map straight onto physical memory, one cached and one uncached, and never look at the stored translations. The user segment and the upper kernel segment are translated through a small, fully associative array of entries. Each entry is tagged with a page number and an address-space identifier. Because the tag includes the identifier, translations that belong to different processes can stay in the array side by side, and a context switch needs no flush.

Refill is done by software. When a mapped access finds no usable translation, the block reports a miss fault. The handler then chooses a slot and loads it through the write port. It can later remove a stale mapping through the invalidate port, either one slot at a time or the whole array at once. A probe port shows the valid, referenced and dirty bits of any slot, so the handler can see which pages were used or modified. A lookup that succeeds marks its entry as referenced, and a store that succeeds also marks it dirty. The lookup result is combinational in the same cycle. The referenced and dirty updates take effect at the next clock edge.

Top module: `tlb_asid_top`

## Requirements
- R1: After reset every slot reads back with valid, referenced and dirty all 0, and every mapped lookup reports fault code 1 (miss).
- R2: A mapped lookup with a usable hit reports fault 0. The physical address is the entry's frame number followed by the 12 untranslated offset bits, and cacheable comes from the entry.
- R3: An entry whose page number matches but whose identifier differs from the current one is not a hit, so the lookup reports fault 1.
- R4: An entry that matches but is stored with valid=0 is not a hit, so the lookup reports fault 1.
- R5: A kernel access with address bits [31:29]=100 reports fault 0, physical address equal to the virtual address with its top three bits cleared, and cacheable=1, whatever the array holds.
- R6: A kernel access with bits [31:29]=101 behaves the same as R5 except that cacheable=0.
- R7: A kernel access with bits [31:30]=11 is translated through the array in the same way as a user-segment access.
- R8: A user-mode access with bit 31 set reports fault code 3 (address error). This code takes precedence over miss and protection.
- R9: A store that hits an entry marked read-only reports fault code 2 (protection). A load to the same entry translates.
- R10: When two or more valid entries match, the lowest-index one supplies the translation and the multi-hit output is 1. Otherwise the multi-hit output is 0.
- R11: A lookup with fault 0 that goes through the array sets the referenced bit of the winning entry. A store with fault 0 also sets its dirty bit. A faulted lookup changes neither bit.
- R12: Invalidating one slot makes later lookups of that slot's mapping miss and leaves every other slot unchanged.
- R13: Invalidating all slots clears every valid bit in one cycle.
- R14: With the lookup strobe low, the outputs read fault 0, physical address 0, cacheable 0 and multi-hit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkValid | input | 1 | Lookup strobe |
| lkVaddr | input | VA_W | Virtual address to translate |
| lkAsid | input | ASID_W | Current address-space identifier |
| lkWrite | input | 1 | 1 for a store, 0 for a load |
| lkUser | input | 1 | 1 when the access comes from user mode |
| lkPaddr | output | PA_W | Translated physical address |
| lkCacheable | output | 1 | The access may be cached |
| lkFault | output | 2 | 0 none, 1 miss, 2 protection, 3 address error |
| lkMultiHit | output | 1 | More than one valid entry matched |
| wrEn | input | 1 | Load the slot selected by wrIndex |
| wrIndex | input | IDX_W | Slot to load |
| wrVpn | input | VPN_W | Virtual page number tag |
| wrAsid | input | ASID_W | Identifier tag |
| wrPfn | input | PFN_W | Physical frame number |
| wrValid | input | 1 | Valid bit |
| wrWritable | input | 1 | 1 read/write, 0 read-only |
| wrCacheable | input | 1 | Cacheable attribute |
| wrDirty | input | 1 | Initial dirty bit |
| wrRef | input | 1 | Initial referenced bit |
| invEn | input | 1 | Invalidate strobe; takes precedence over a write in the same cycle |
| invAll | input | 1 | With invEn, clear every slot |
| invIndex | input | IDX_W | Slot cleared when invAll is 0 |
| rdIndex | input | IDX_W | Slot shown on the probe outputs |
| rdValid | output | 1 | Valid bit of the probed slot |
| rdRef | output | 1 | Referenced bit of the probed slot |
| rdDirty | output | 1 | Dirty bit of the probed slot |

## Verification
The bench builds the block with 8 slots and a 2-bit identifier, keeping the 12-bit offset and 20-bit frame. With this configuration every stored mapping can be looked up under every identifier, in both access directions and both privilege modes. That sweep covers identifier mismatch, slots loaded with valid=0, read-only stores and the precedence of user address errors over the other faults. Duplicate-slot, single-invalidate and full-invalidate cases then fit into a few extra steps. Referenced and dirty bits are checked after every sweep step through the probe port.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PROT = 2'd2,
    FLT_ADDR = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    SEG_MAPPED   = 2'd0,
    SEG_DIRECT_C = 2'd1,
    SEG_DIRECT_U = 2'd2
  } seg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setRef;
    logic setDirty;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 6,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  input  tlbStrobe_t        strobe,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [PFN_W-1:0]  hitPfn,
  output logic              hitWritable,
  output logic              hitCacheable,
  output logic              multiMatch,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [PFN_W-1:0]  wrPfn,
  input  logic              wrValid,
  input  logic              wrWritable,
  input  logic              wrCacheable,
  input  logic              wrDirty,
  input  logic              wrRef,
  input  logic              invEn,
  input  logic              invAll,
  input  logic [IDX_W-1:0]  invIndex,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic              rdValid,
  output logic              rdRef,
  output logic              rdDirty
);

  logic [VPN_W-1:0]   vpnQ   [ENTRIES];
  logic [ASID_W-1:0]  asidQ  [ENTRIES];
  logic [PFN_W-1:0]   pfnQ   [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] writQ;
  logic [ENTRIES-1:0] cachQ;
  logic [ENTRIES-1:0] refQ;
  logic [ENTRIES-1:0] dirtyQ;
  logic [ENTRIES-1:0] matchVec;

  // parallel compare of every slot
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = validQ[g] && (vpnQ[g] == lkVpn) && (asidQ[g] == lkAsid);
  end

  // lowest index wins
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
    multiMatch = ($countones(matchVec) > 1);
  end

  assign hitPfn       = pfnQ[hitIdx];
  assign hitWritable  = writQ[hitIdx];
  assign hitCacheable = cachQ[hitIdx];

  assign rdValid = validQ[rdIndex];
  assign rdRef   = refQ[rdIndex];
  assign rdDirty = dirtyQ[rdIndex];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
      writQ  <= '0;
      cachQ  <= '0;
      refQ   <= '0;
      dirtyQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i]  <= '0;
        asidQ[i] <= '0;
        pfnQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (invEn && (invAll || invIndex == IDX_W'(i))) begin
          validQ[i] <= 1'b0;
        end else if (wrEn && wrIndex == IDX_W'(i)) begin
          vpnQ[i]   <= wrVpn;
          asidQ[i]  <= wrAsid;
          pfnQ[i]   <= wrPfn;
          validQ[i] <= wrValid;
          writQ[i]  <= wrWritable;
          cachQ[i]  <= wrCacheable;
          refQ[i]   <= wrRef;
          dirtyQ[i] <= wrDirty;
        end else if (hit && hitIdx == IDX_W'(i)) begin
          if (strobe.setRef)   refQ[i]   <= 1'b1;
          if (strobe.setDirty) dirtyQ[i] <= 1'b1;
        end
      end
    end
  end

  AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (invEn && invAll) |=> (validQ == '0)); // R13

  AST_STORE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.setDirty && !wrEn && !invEn) |=> dirtyQ[$past(hitIdx)]); // R11

  AST_STROBE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.setRef |-> hit); // R11

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic             lkWrite,
  input  logic             lkUser,
  input  logic             hit,
  input  logic [PFN_W-1:0] hitPfn,
  input  logic             hitWritable,
  input  logic             hitCacheable,
  input  logic             multiMatch,
  output logic [PA_W-1:0]  paddr,
  output logic             cacheable,
  output fault_e           fault,
  output logic             multiHit,
  output tlbStrobe_t       strobe
);

  seg_e seg;

  always_comb begin
    unique casez (lkVaddr[VA_W-1 -: 3])
      3'b100:  seg = SEG_DIRECT_C;
      3'b101:  seg = SEG_DIRECT_U;
      default: seg = SEG_MAPPED;
    endcase
  end

  always_comb begin
    fault     = FLT_NONE;
    paddr     = '0;
    cacheable = 1'b0;
    multiHit  = 1'b0;
    strobe    = '0;
    if (lkValid) begin
      if (lkUser && lkVaddr[VA_W-1]) begin
        fault = FLT_ADDR;
      end else if (seg != SEG_MAPPED) begin
        paddr     = PA_W'(lkVaddr[VA_W-4:0]);
        cacheable = (seg == SEG_DIRECT_C);
      end else begin
        multiMatch_out: multiHit = multiMatch;
        if (!hit) begin
          fault = FLT_MISS;
        end else if (lkWrite && !hitWritable) begin
          fault = FLT_PROT;
        end else begin
          paddr           = {hitPfn, lkVaddr[OFF_W-1:0]};
          cacheable       = hitCacheable;
          strobe.setRef   = 1'b1;
          strobe.setDirty = lkWrite;
        end
      end
    end
  end

endmodule

// File: rtl/tlb_asid_top.sv
module tlb_asid_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 6,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkWrite,
  input  logic              lkUser,
  output logic [PA_W-1:0]   lkPaddr,
  output logic              lkCacheable,
  output logic [1:0]        lkFault,
  output logic              lkMultiHit,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [PFN_W-1:0]  wrPfn,
  input  logic              wrValid,
  input  logic              wrWritable,
  input  logic              wrCacheable,
  input  logic              wrDirty,
  input  logic              wrRef,
  input  logic              invEn,
  input  logic              invAll,
  input  logic [IDX_W-1:0]  invIndex,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic              rdValid,
  output logic              rdRef,
  output logic              rdDirty
);

  tlbStrobe_t       strobe;
  logic             hit, hitWritable, hitCacheable, multiMatch;
  logic [IDX_W-1:0] hitIdx;
  logic [PFN_W-1:0] hitPfn;
  fault_e           faultCode;

  tlb_datapath #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n),
    .lkVpn(lkVaddr[VA_W-1:OFF_W]), .lkAsid(lkAsid), .strobe(strobe),
    .hit(hit), .hitIdx(hitIdx), .hitPfn(hitPfn), .hitWritable(hitWritable),
    .hitCacheable(hitCacheable), .multiMatch(multiMatch),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrVpn(wrVpn), .wrAsid(wrAsid), .wrPfn(wrPfn),
    .wrValid(wrValid), .wrWritable(wrWritable), .wrCacheable(wrCacheable),
    .wrDirty(wrDirty), .wrRef(wrRef),
    .invEn(invEn), .invAll(invAll), .invIndex(invIndex),
    .rdIndex(rdIndex), .rdValid(rdValid), .rdRef(rdRef), .rdDirty(rdDirty)
  );

  tlb_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
  ) ctrl_i (
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkWrite(lkWrite), .lkUser(lkUser),
    .hit(hit), .hitPfn(hitPfn), .hitWritable(hitWritable),
    .hitCacheable(hitCacheable), .multiMatch(multiMatch),
    .paddr(lkPaddr), .cacheable(lkCacheable), .fault(faultCode),
    .multiHit(lkMultiHit), .strobe(strobe)
  );

  assign lkFault = faultCode;

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && lkFault == FLT_NONE) |-> (lkPaddr[OFF_W-1:0] == lkVaddr[OFF_W-1:0])); // R2

  AST_USER_HIGH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && lkUser && lkVaddr[VA_W-1]) |-> (lkFault == FLT_ADDR)); // R8

  AST_DIRECT_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && !lkUser && lkVaddr[VA_W-1 -: 3] == 3'b101) |-> (!lkCacheable && lkFault == FLT_NONE)); // R6

  AST_MULTI_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lkMultiHit |-> (lkFault == FLT_NONE || lkFault == FLT_PROT)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lkValid |-> (lkFault == FLT_NONE && !lkMultiHit && !lkCacheable)); // R14

endmodule

// File: tb/tlb_asid_top_tb_top.sv
module tlb_asid_top_tb_top;

  localparam int N   = 8;
  localparam int AW  = 2;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          lkValid = 0, lkWrite = 0, lkUser = 0;
  logic [31:0]   lkVaddr = 0;
  logic [AW-1:0] lkAsid = 0;
  logic [31:0]   lkPaddr;
  logic          lkCacheable, lkMultiHit;
  logic [1:0]    lkFault;
  logic          wrEn = 0, wrValid = 0, wrWritable = 0, wrCacheable = 0, wrDirty = 0, wrRef = 0;
  logic [IW-1:0] wrIndex = 0, invIndex = 0, rdIndex = 0;
  logic [19:0]   wrVpn = 0, wrPfn = 0;
  logic [AW-1:0] wrAsid = 0;
  logic          invEn = 0, invAll = 0;
  logic          rdValid, rdRef, rdDirty;

  tlb_asid_top #(.ENTRIES(N), .ASID_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkAsid(lkAsid), .lkWrite(lkWrite), .lkUser(lkUser),
    .lkPaddr(lkPaddr), .lkCacheable(lkCacheable), .lkFault(lkFault), .lkMultiHit(lkMultiHit),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrVpn(wrVpn), .wrAsid(wrAsid), .wrPfn(wrPfn),
    .wrValid(wrValid), .wrWritable(wrWritable), .wrCacheable(wrCacheable),
    .wrDirty(wrDirty), .wrRef(wrRef),
    .invEn(invEn), .invAll(invAll), .invIndex(invIndex),
    .rdIndex(rdIndex), .rdValid(rdValid), .rdRef(rdRef), .rdDirty(rdDirty)
  );

  int checks = 0;
  int failures = 0;

  // reference model of slot contents, from the requirements
  logic [19:0]   mVpn [N];
  logic [AW-1:0] mAsid [N];
  logic [19:0]   mPfn [N];
  logic          mValid [N], mWr [N], mCach [N], mRef [N], mDirty [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lkValid = 0; wrEn = 0; invEn = 0; invAll = 0;
  endtask

  task automatic doWrite(input int idx, input logic [19:0] vpn, input logic [AW-1:0] asid,
                         input logic [19:0] pfn, input bit v, input bit w, input bit c);
    @(negedge clk);
    idle();
    wrEn = 1; wrIndex = IW'(idx); wrVpn = vpn; wrAsid = asid; wrPfn = pfn;
    wrValid = v; wrWritable = w; wrCacheable = c; wrDirty = 0; wrRef = 0;
    @(posedge clk);
    mVpn[idx] = vpn; mAsid[idx] = asid; mPfn[idx] = pfn; mValid[idx] = v;
    mWr[idx] = w; mCach[idx] = c; mRef[idx] = 0; mDirty[idx] = 0;
  endtask

  task automatic doInv(input bit all, input int idx);
    @(negedge clk);
    idle();
    invEn = 1; invAll = all; invIndex = IW'(idx);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (all || i == idx) mValid[i] = 0;
  endtask

  task automatic probe(input int idx, input string req);
    @(negedge clk);
    idle();
    rdIndex = IW'(idx);
    #1;
    chk(rdValid == mValid[idx], req, "probe valid", 64'(rdValid), 64'(mValid[idx]));
    chk(rdRef == mRef[idx], req, "probe referenced", 64'(rdRef), 64'(mRef[idx]));
    chk(rdDirty == mDirty[idx], req, "probe dirty", 64'(rdDirty), 64'(mDirty[idx]));
  endtask

  // lookup with expected values derived from the requirements
  task automatic doLookup(input logic [31:0] va, input logic [AW-1:0] asid,
                          input bit wr, input bit user, input string req);
    logic [31:0] ePa;
    logic [1:0]  eFlt;
    bit          eC, eMulti;
    int          win, cnt;
    ePa = 0; eFlt = 0; eC = 0; eMulti = 0; win = -1; cnt = 0;
    if (user && va[31]) eFlt = 3;
    else if (va[31:29] == 3'b100) begin ePa = {3'b000, va[28:0]}; eC = 1; end
    else if (va[31:29] == 3'b101) begin ePa = {3'b000, va[28:0]}; eC = 0; end
    else begin
      for (int i = 0; i < N; i++)
        if (mValid[i] && mVpn[i] == va[31:12] && mAsid[i] == asid) begin
          cnt++;
          if (win < 0) win = i;
        end
      eMulti = (cnt > 1);
      if (win < 0) eFlt = 1;
      else if (wr && !mWr[win]) eFlt = 2;
      else begin ePa = {mPfn[win], va[11:0]}; eC = mCach[win]; end
    end
    @(negedge clk);
    idle();
    lkValid = 1; lkVaddr = va; lkAsid = asid; lkWrite = wr; lkUser = user;
    #1;
    chk(lkFault == eFlt, req, "fault", 64'(lkFault), 64'(eFlt));
    chk(lkPaddr == ePa, req, "paddr", 64'(lkPaddr), 64'(ePa));
    chk(lkCacheable == eC, req, "cacheable", 64'(lkCacheable), 64'(eC));
    chk(lkMultiHit == eMulti, req, "multi-hit", 64'(lkMultiHit), 64'(eMulti));
    @(posedge clk);
    if (eFlt == 0 && win >= 0) begin
      mRef[win] = 1;
      if (wr) mDirty[win] = 1;
    end
  endtask

  function automatic string sweepTag(input int i, input logic [AW-1:0] a, input bit wr, input bit user);
    if (user && mVpn[i][19]) return "R8";
    if (mAsid[i] != a) return "R3";
    if (!mValid[i]) return "R4";
    if (wr && !mWr[i]) return "R9";
    if (mVpn[i][19]) return "R7";
    return "R2";
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      mVpn[i] = 0; mAsid[i] = 0; mPfn[i] = 0; mValid[i] = 0;
      mWr[i] = 0; mCach[i] = 0; mRef[i] = 0; mDirty[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < N; i++) probe(i, "R1");
    doLookup(32'h0000_1234, 0, 0, 0, "R1");
    doLookup(32'hC000_5678, 1, 1, 0, "R1");

    // R14 idle outputs
    @(negedge clk); idle(); lkVaddr = 32'h8000_0010; #1;
    chk(lkFault == 0 && lkPaddr == 0 && !lkCacheable && !lkMultiHit, "R14", "idle outputs",
        {lkFault, lkCacheable, lkMultiHit, lkPaddr}, 64'h0);

    // R5 / R6 / R8 direct segments swept over offsets
    for (int k = 0; k < 8; k++) begin
      doLookup({3'b100, 29'(k * 32'h0345_6789)}, AW'(k), k[0], 0, "R5");
      doLookup({3'b101, 29'(k * 32'h0123_4567)}, AW'(k), k[0], 0, "R6");
      doLookup({3'b100, 29'(k * 32'h0111_1111)}, AW'(k), k[0], 1, "R8");
    end

    // fill all slots: even slots user segment, odd slots upper kernel segment
    for (int i = 0; i < N; i++)
      doWrite(i, (i % 2 == 0) ? 20'(32'h00100 + i * 13) : 20'(32'hE0000 + i * 7),
              AW'(i % 4), 20'(32'h400 + i * 9), (i != 5), i[0] | i[2], i[1]);

    // exhaustive sweep: slot x identifier x direction x privilege
    for (int i = 0; i < N; i++)
      for (int a = 0; a < (1 << AW); a++)
        for (int w = 0; w < 2; w++)
          for (int u = 0; u < 2; u++) begin
            doLookup({mVpn[i], 12'(i * 32'h111 + a)}, AW'(a), w[0], u[0],
                     sweepTag(i, AW'(a), w[0], u[0]));
            probe(i, "R11");
          end

    // R11 referenced and dirty from a fresh slot
    doWrite(2, 20'h0ABCD, 2'd1, 20'h12345, 1, 1, 1);
    probe(2, "R11");
    doLookup(32'h0ABC_D010, 2'd1, 0, 1, "R11");
    probe(2, "R11");
    doLookup(32'h0ABC_D020, 2'd1, 1, 1, "R11");
    probe(2, "R11");
    // faulted store on read-only slot leaves bits alone (R9, R11)
    doWrite(4, 20'h05555, 2'd2, 20'h0AAAA, 1, 0, 0);
    doLookup(32'h0555_5fff, 2'd2, 1, 0, "R9");
    probe(4, "R11");
    doLookup(32'h0555_5001, 2'd2, 0, 0, "R9");
    probe(4, "R11");

    // R10 duplicate mapping: slot 6 copies slot 1 with another frame
    doWrite(6, mVpn[1], mAsid[1], 20'hFEDCB, 1, 1, 0);
    doLookup({mVpn[1], 12'h3C3}, mAsid[1], 0, 0, "R10");

    // R12 single invalidate
    doInv(0, 1);
    doLookup({mVpn[1], 12'h3C4}, mAsid[1], 0, 0, "R12");
    doInv(0, 6);
    doLookup({mVpn[1], 12'h3C5}, mAsid[1], 0, 0, "R12");
    for (int i = 0; i < N; i++) probe(i, "R12");
    doLookup({mVpn[0], 12'h001}, mAsid[0], 0, 0, "R12");

    // R13 invalidate all
    doInv(1, 0);
    for (int i = 0; i < N; i++) probe(i, "R13");
    doLookup({mVpn[3], 12'h002}, mAsid[3], 0, 0, "R13");
    doLookup({mVpn[0], 12'h003}, mAsid[0], 0, 0, "R13");

    @(negedge clk); idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule